// File: doc/BRIEF.md
# Byte-Stream Memory Command Engine

This block takes request packets on an 8-bit valid/ready byte stream, whose last byte is flagged by a marker, and executes them against a small internal byte RAM. Each request starts with a type byte. Reads and writes then carry a one-byte address and a 16-bit little-endian byte count, and writes carry their data bytes after that. Every request that is understood gets one response packet on a second byte stream. The response starts with its own type code and repeats the request's address and count. A read response then carries the data bytes.

An identify request needs no header and is answered with a fixed descriptor. The engine handles one request at a time. While a response is being sent it refuses input, so responses leave in the same order as their requests. Malformed or unknown packets are dropped without a response.

Top module: `mem_cmd_proc`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, and every RAM byte reads as 0x00.
- R2: A read request is the type byte 0x10, then the address A, then count low, then count high. Its response is 0x11, A, count low, count high, and then `count` bytes. Data byte j is the RAM byte at index (A+j) mod 2^RAM_AW. `out_last` is set only on the final byte.
- R3: A write request is 0x12, A, count low, count high, then the data bytes. Data byte j is stored at index (A+j) mod 2^RAM_AW. The response is exactly four bytes, 0x13, A, count low, count high, with `out_last` on the fourth.
- R4: An identify request starts with type byte 0xFE, and any further bytes in that packet are ignored. The response is 0xFF followed by ID_LEN bytes, where descriptor byte k has value ID_BASE+k (0xA0+k by default, 32 bytes). `out_last` is on the final descriptor byte.
- R5: The response is emitted only after the request's last byte has been accepted. `in_ready` stays 0 from then until the response's last byte has been transferred, and returns to 1 on the next cycle.
- R6: A packet whose type byte is none of 0x10, 0x12 or 0xFE is consumed without producing any response and without changing the RAM.
- R7: A read or write packet that ends before its three header bytes are complete is consumed without producing any response and without changing the RAM.
- R8: RAM indexing uses only the low RAM_AW bits of the address (64 bytes by default). The index wraps from the top of the RAM back to 0 within one access. The response still echoes the full address byte.
- R9: If a write packet carries fewer data bytes than its count, only the bytes received are stored, and the response still echoes the address and count unchanged. Data bytes beyond the count are not stored.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values.
- R11: A read with count 0 is answered with only the four header bytes, with `out_last` on the fourth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | 8 | Request stream byte |
| in_valid | input | 1 | Request byte present |
| in_last | input | 1 | Marks the final byte of a request packet |
| in_ready | output | 1 | Engine accepts a request byte this cycle |
| out_data | output | 8 | Response stream byte |
| out_valid | output | 1 | Response byte present |
| out_last | output | 1 | Marks the final byte of a response packet |
| out_ready | input | 1 | Downstream accepts a response byte this cycle |

## Verification
A wrong parser state shows up on the first response after the fault, within a few cycles of the request's last byte. The response may be missing, may carry the wrong type code, or may echo a shifted address or count. It may also appear for a packet that should have been dropped. A faulty write pointer or wrap computation stays hidden until a later read of the affected bytes, so every write scenario is followed by a read that covers the same range, including the bytes just past a short write. A faulty response counter shows up as a mis-placed `out_last` or a response length that differs from the 4+count or 1+ID_LEN rule. Data that changes during a stall is caught on the cycle after the stall begins.

// File: rtl/mcp_pkg.sv
package mcp_pkg;

    typedef enum logic [2:0] {
        ST_TYPE,
        ST_HDR,
        ST_WDATA,
        ST_SKIP,
        ST_RSP
    } st_e;

    typedef enum logic [1:0] {
        OP_READ,
        OP_WRITE,
        OP_IDENT
    } op_e;

    localparam logic [7:0] T_RD_REQ = 8'h10;
    localparam logic [7:0] T_RD_RSP = 8'h11;
    localparam logic [7:0] T_WR_REQ = 8'h12;
    localparam logic [7:0] T_WR_RSP = 8'h13;
    localparam logic [7:0] T_ID_REQ = 8'hFE;
    localparam logic [7:0] T_ID_RSP = 8'hFF;

    localparam int RSP_HDR_LEN = 4;

    typedef struct packed {
        st_e         st;
        op_e         op;
        logic [7:0]  addr;
        logic [15:0] cnt;
        logic [16:0] idx;
        logic        pend;
    } ctx_t;

endpackage

// File: rtl/mcp_byte_ram.sv
module mcp_byte_ram #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= 8'h00;
            end
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/mcp_ident_rom.sv
module mcp_ident_rom #(
    parameter int         IW   = 8,
    parameter logic [7:0] BASE = 8'hA0
) (
    input  logic [IW-1:0] idx,
    output logic [7:0]    data
);
    always_comb begin
        data = BASE + 8'(idx);
    end
endmodule

// File: rtl/mem_cmd_proc.sv
module mem_cmd_proc
    import mcp_pkg::*;
#(
    parameter int         RAM_AW  = 6,
    parameter int         ID_LEN  = 32,
    parameter logic [7:0] ID_BASE = 8'hA0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    input  logic       in_last,
    output logic       in_ready,
    output logic [7:0] out_data,
    output logic       out_valid,
    output logic       out_last,
    input  logic       out_ready
);
    localparam int          IDX_W   = 17;
    localparam logic [16:0] ID_RLEN = IDX_W'(ID_LEN + 1);
    localparam logic [16:0] HDR_LEN = IDX_W'(RSP_HDR_LEN);

    ctx_t q, d;

    logic              wr_en;
    logic [RAM_AW-1:0] wr_a;
    logic [RAM_AW-1:0] rd_a;
    logic [7:0]        ram_rd;
    logic [7:0]        id_byte;
    logic [7:0]        id_idx;
    logic [16:0]       rsp_len;
    logic              accept;

    assign wr_a   = q.addr[RAM_AW-1:0] + q.idx[RAM_AW-1:0];
    assign rd_a   = q.addr[RAM_AW-1:0] + q.idx[RAM_AW-1:0] - RAM_AW'(RSP_HDR_LEN);
    assign id_idx = q.idx[7:0] - 8'd1;

    mcp_byte_ram #(.AW(RAM_AW)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (wr_a),
        .wdata (in_data),
        .raddr (rd_a),
        .rdata (ram_rd)
    );

    mcp_ident_rom #(.IW(8), .BASE(ID_BASE)) u_rom (
        .idx  (id_idx),
        .data (id_byte)
    );

    // response length per operation
    always_comb begin
        case (q.op)
            OP_READ:  rsp_len = IDX_W'(q.cnt) + HDR_LEN;
            OP_IDENT: rsp_len = ID_RLEN;
            default:  rsp_len = HDR_LEN;
        endcase
    end

    // response byte selection
    always_comb begin
        out_valid = (q.st == ST_RSP);
        out_last  = out_valid && (q.idx == rsp_len - 17'd1);
        if (q.op == OP_IDENT) begin
            out_data = (q.idx == 17'd0) ? T_ID_RSP : id_byte;
        end else begin
            case (q.idx)
                17'd0:   out_data = (q.op == OP_READ) ? T_RD_RSP : T_WR_RSP;
                17'd1:   out_data = q.addr;
                17'd2:   out_data = q.cnt[7:0];
                17'd3:   out_data = q.cnt[15:8];
                default: out_data = ram_rd;
            endcase
        end
    end

    // next-state computation
    always_comb begin
        d        = q;
        wr_en    = 1'b0;
        in_ready = (q.st != ST_RSP);
        accept   = in_valid && in_ready;

        case (q.st)
            ST_TYPE: begin
                if (accept) begin
                    d.idx  = '0;
                    d.pend = 1'b0;
                    case (in_data)
                        T_RD_REQ: begin
                            d.op = OP_READ;
                            d.st = in_last ? ST_TYPE : ST_HDR;
                        end
                        T_WR_REQ: begin
                            d.op = OP_WRITE;
                            d.st = in_last ? ST_TYPE : ST_HDR;
                        end
                        T_ID_REQ: begin
                            d.op   = OP_IDENT;
                            d.st   = in_last ? ST_RSP : ST_SKIP;
                            d.pend = 1'b1;
                        end
                        default: begin
                            d.st = in_last ? ST_TYPE : ST_SKIP;
                        end
                    endcase
                end
            end

            ST_HDR: begin
                if (accept) begin
                    case (q.idx[1:0])
                        2'd0:    d.addr      = in_data;
                        2'd1:    d.cnt[7:0]  = in_data;
                        default: d.cnt[15:8] = in_data;
                    endcase
                    d.idx = q.idx + 17'd1;
                    if (q.idx == 17'd2) begin
                        d.idx = '0;
                        if (q.op == OP_READ) begin
                            d.pend = 1'b1;
                            d.st   = in_last ? ST_RSP : ST_SKIP;
                        end else begin
                            d.st = in_last ? ST_RSP : ST_WDATA;
                        end
                    end else if (in_last) begin
                        d.st = ST_TYPE;
                    end
                end
            end

            ST_WDATA: begin
                if (accept) begin
                    if (q.idx < IDX_W'(q.cnt)) begin
                        wr_en = 1'b1;
                        d.idx = q.idx + 17'd1;
                    end
                    if (in_last) begin
                        d.idx = '0;
                        d.st  = ST_RSP;
                    end
                end
            end

            ST_SKIP: begin
                if (accept && in_last) begin
                    d.idx = '0;
                    d.st  = q.pend ? ST_RSP : ST_TYPE;
                end
            end

            default: begin
                if (out_ready) begin
                    if (out_last) begin
                        d.st   = ST_TYPE;
                        d.idx  = '0;
                        d.pend = 1'b0;
                    end else begin
                        d.idx = q.idx + 17'd1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_TYPE, op: OP_READ, addr: '0, cnt: '0, idx: '0, pend: 1'b0};
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/mcp_checker.sv
module mcp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       in_ready,
    input logic [7:0] out_data,
    input logic       out_valid,
    input logic       out_last,
    input logic       out_ready
);
    p_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (!out_valid && in_ready));

    p_hold_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_hold_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable(out_last));

    p_last_qual_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    p_rsp_type_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_data == 8'h11 || out_data == 8'h13 || out_data == 8'hFF));
endmodule

bind mem_cmd_proc mcp_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_last  (out_last),
    .out_ready (out_ready)
);

// File: tb/mem_cmd_proc_test.sv
module mem_cmd_proc_test;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_last;
    logic       out_ready = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] txb [64];
    int         txn;
    logic [7:0] rxb [64];
    int         rxn;
    int         last_idx;
    bit         hold_bad;

    always #(PERIOD/2) clk = ~clk;

    mem_cmd_proc uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_ready  (in_ready),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_last  (out_last),
        .out_ready (out_ready)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send();
        for (int i = 0; i < txn; i++) begin
            @(negedge clk);
            in_data  = txb[i];
            in_valid = 1'b1;
            in_last  = (i == txn - 1);
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic recv(input bit stall);
        int guard = 0;
        bit prev_stall = 1'b0;
        logic [7:0] prev_d = 8'h00;
        logic prev_l = 1'b0;
        rxn = 0;
        last_idx = -1;
        hold_bad = 1'b0;
        while (last_idx < 0 && guard < 3000 && rxn < 64) begin
            @(negedge clk);
            out_ready = stall ? (guard % 2 == 1) : 1'b1;
            guard++;
            if (prev_stall && (!out_valid || out_data != prev_d || out_last != prev_l))
                hold_bad = 1'b1;
            prev_stall = out_valid && !out_ready;
            prev_d = out_data;
            prev_l = out_last;
            if (out_valid && out_ready) begin
                rxb[rxn] = out_data;
                if (out_last) last_idx = rxn;
                rxn++;
            end
        end
        @(posedge clk);
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic quiet(input string tag, input int cycles);
        bit seen = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (out_valid) seen = 1'b1;
        end
        chk(tag, int'(seen), 0);
    endtask

    task automatic put4(input logic [7:0] t, input logic [7:0] a, input logic [15:0] c);
        txb[0] = t; txb[1] = a; txb[2] = c[7:0]; txb[3] = c[15:8];
        txn = 4;
    endtask

    task automatic chk_hdr(input string tag, input logic [7:0] t, input logic [7:0] a,
                           input logic [15:0] c);
        chk({tag, " type"}, rxb[0], t);
        chk({tag, " addr"}, rxb[1], a);
        chk({tag, " cnt"}, {rxb[3], rxb[2]}, c);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 in_ready", in_ready, 1);
        chk("R1 out_valid", out_valid, 0);
        put4(8'h10, 8'h08, 16'd2);
        send();
        recv(1'b0);
        chk("R1 ram zero b0", rxb[4], 8'h00);
        chk("R1 ram zero b1", rxb[5], 8'h00);
    endtask

    task automatic t_write_read();
        put4(8'h12, 8'h00, 16'd4);
        txb[4] = 8'h11; txb[5] = 8'h22; txb[6] = 8'h33; txb[7] = 8'h44;
        txn = 8;
        send();
        chk("R5 busy after write", in_ready, 0);
        recv(1'b0);
        chk("R3 ack length", rxn, 4);
        chk("R3 ack last", last_idx, 3);
        chk_hdr("R3", 8'h13, 8'h00, 16'd4);
        put4(8'h10, 8'h00, 16'd4);
        send();
        chk("R5 out_valid after read", out_valid, 1);
        chk("R5 in_ready low", in_ready, 0);
        recv(1'b0);
        chk("R5 ready back", in_ready, 1);
        chk("R2 rsp length", rxn, 8);
        chk("R2 last pos", last_idx, 7);
        chk_hdr("R2", 8'h11, 8'h00, 16'd4);
        chk("R2 data", {rxb[4], rxb[5], rxb[6], rxb[7]}, 32'h11223344);
    endtask

    task automatic t_ident();
        int bad = 0;
        txb[0] = 8'hFE; txb[1] = 8'h99; txn = 2;
        send();
        recv(1'b0);
        chk("R4 length", rxn, 33);
        chk("R4 last pos", last_idx, 32);
        chk("R4 type", rxb[0], 8'hFF);
        for (int k = 0; k < 32; k++) begin
            if (rxb[k+1] != 8'(8'hA0 + k)) bad++;
        end
        chk("R4 descriptor bytes", bad, 0);
    endtask

    task automatic t_unknown();
        txb[0] = 8'h55; txb[1] = 8'h02; txb[2] = 8'h01; txb[3] = 8'h00; txb[4] = 8'h77;
        txn = 5;
        send();
        quiet("R6 no response", 20);
        put4(8'h10, 8'h02, 16'd1);
        send();
        recv(1'b0);
        chk("R6 ram untouched", rxb[4], 8'h33);
    endtask

    task automatic t_trunc();
        txb[0] = 8'h12; txb[1] = 8'h02; txb[2] = 8'h01; txn = 3;
        send();
        quiet("R7 short write header", 20);
        txb[0] = 8'h10; txn = 1;
        send();
        quiet("R7 bare read type", 20);
        put4(8'h10, 8'h02, 16'd1);
        send();
        recv(1'b0);
        chk("R7 ram untouched", rxb[4], 8'h33);
    endtask

    task automatic t_wrap();
        put4(8'h12, 8'd62, 16'd4);
        txb[4] = 8'h01; txb[5] = 8'h02; txb[6] = 8'h03; txb[7] = 8'h04;
        txn = 8;
        send();
        recv(1'b0);
        chk_hdr("R8 wr ack", 8'h13, 8'd62, 16'd4);
        put4(8'h10, 8'h00, 16'd2);
        send();
        recv(1'b0);
        chk("R8 wrapped bytes", {rxb[4], rxb[5]}, 16'h0304);
        put4(8'h10, 8'h7E, 16'd2);
        send();
        recv(1'b0);
        chk("R8 echo full addr", rxb[1], 8'h7E);
        chk("R8 high addr bits dropped", {rxb[4], rxb[5]}, 16'h0102);
    endtask

    task automatic t_short();
        put4(8'h12, 8'd10, 16'd4);
        txb[4] = 8'hAA; txb[5] = 8'hBB; txn = 6;
        send();
        recv(1'b0);
        chk("R9 ack length", rxn, 4);
        chk_hdr("R9 ack", 8'h13, 8'd10, 16'd4);
        put4(8'h10, 8'd10, 16'd4);
        send();
        recv(1'b0);
        chk("R9 partial data", {rxb[4], rxb[5], rxb[6], rxb[7]}, 32'hAABB0000);
        put4(8'h12, 8'd20, 16'd1);
        txb[4] = 8'h05; txb[5] = 8'h06; txn = 6;
        send();
        recv(1'b0);
        put4(8'h10, 8'd20, 16'd2);
        send();
        recv(1'b0);
        chk("R9 excess not stored", {rxb[4], rxb[5]}, 16'h0500);
    endtask

    task automatic t_stall();
        put4(8'h10, 8'h00, 16'd4);
        send();
        recv(1'b1);
        chk("R10 held during stall", int'(hold_bad), 0);
        chk("R10 data under stall", {rxb[4], rxb[5], rxb[6], rxb[7]}, 32'h03043344);
        chk("R10 length under stall", rxn, 8);
    endtask

    task automatic t_zero();
        put4(8'h10, 8'h05, 16'd0);
        send();
        recv(1'b0);
        chk("R11 length", rxn, 4);
        chk("R11 last pos", last_idx, 3);
        chk_hdr("R11", 8'h11, 8'h05, 16'd0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_read();
        t_ident();
        t_unknown();
        t_trunc();
        t_wrap();
        t_short();
        t_stall();
        t_zero();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule